// File: doc/BRIEF.md
# Subset-Aware Group Register Renamer

This block renames a group of up to four instructions per clock for a machine whose physical register file is split into write subsets. Each cluster writes only the registers of its own subset, so each subset keeps a separate free list. The subset is given by the low bits of the physical register number. With the default of two subsets, one list holds the even registers and the other holds the odd ones. The cluster choice is made upstream and arrives with the group as a per-instruction subset vector. The block only honours that choice.

For every accepted group the block tallies the destinations each subset needs. It takes exactly that many entries from the front of each free list. Sources and previous mappings are resolved against earlier writers in the same group and otherwise against the map table as it stood before the group. The map table is then updated, with the youngest writer winning. If any list is too short, the whole group is held off. A single retire port returns a freed register to the list its low bits select. All results are registered and appear one clock after acceptance.

Top module: `wsr_renamer`

## Requirements
- R1: After reset, logical register L maps to physical register L. The list for subset s holds, from its front, the registers NLOG+s, NLOG+s+NSUB, NLOG+s+2·NSUB and so on, up to NPHYS-1. With the defaults these are 16,18,…,62 for subset 0 and 17,19,…,63 for subset 1. `out_valid` is low.
- R2: Every allocated destination for lane i has its low bits (bit 0 with two subsets) equal to that lane's subset field. A value of 0 selects the even list and 1 selects the odd list.
- R3: Within a group, the k-th lane (in lane order 0→3) that has a valid destination in subset s receives the k-th entry from the front of list s. Exactly that many entries leave the list.
- R4: A source of lane i that names the logical destination of an earlier valid lane j<i in the same group receives the new register of the youngest such j.
- R5: A source with no earlier producer in the group receives the map-table entry as it was before the group.
- R6: After an accepted group, each written logical register maps to the new register of its youngest writer in the group.
- R7: `out_old_preg` for a valid lane gives the previous mapping of its logical destination. An earlier writer in the same group counts as that previous mapping. Lanes without a destination report 0 in both `out_dst_preg` and `out_old_preg`.
- R8: When `in_valid` is high and some subset needs more registers than its list holds, `grp_stall` is high in that same cycle. Nothing is popped, the map is unchanged and `out_valid` is low next cycle.
- R9: A register presented on the retire port is appended to the back of the list selected by its low bits. It is handed out again after the entries already in that list.
- R10: An accepted group produces its results with `out_valid` high exactly one clock later. A cycle with `in_valid` low produces `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A group is presented |
| in_dst_vld | input | GROUP | Lane has a destination |
| in_dst_log | input | GROUP*LOG_W | Logical destination per lane |
| in_srca_log | input | GROUP*LOG_W | First logical source per lane |
| in_srcb_log | input | GROUP*LOG_W | Second logical source per lane |
| in_subset | input | GROUP*SUB_W | Write-subset choice per lane |
| ret_valid | input | 1 | A retired register is returned |
| ret_preg | input | PHYS_W | Returned physical register |
| grp_stall | output | 1 | Group cannot be accepted this cycle |
| out_valid | output | 1 | Registered results are valid |
| out_dst_vld | output | GROUP | Registered copy of destination valid |
| out_dst_preg | output | GROUP*PHYS_W | New physical destination per lane |
| out_old_preg | output | GROUP*PHYS_W | Previous mapping per lane |
| out_srca_preg | output | GROUP*PHYS_W | Renamed first source per lane |
| out_srcb_preg | output | GROUP*PHYS_W | Renamed second source per lane |

## Verification
The bench drives groups where one logical register is written twice and then read by a later lane. A renamer that took the oldest writer, or read the map table, would return a stale register for that source and for the old mapping. It drains the even list with all-even groups until the stall must appear. A design that popped a partial group during a stall would then hand out shifted registers on every later allocation. Random traffic mixes lanes without destinations and skewed subset vectors with retirements in the same cycle as pops. A wrong list choice on retire, or a wrong position within a list, breaks the order of the model's queues.

// File: rtl/wsr_pkg.sv
`timescale 1ns/1ps
package wsr_pkg;
  localparam int DEF_GROUP = 4;
  localparam int DEF_NLOG  = 16;
  localparam int DEF_NPHYS = 64;
  localparam int DEF_NSUB  = 2;
endpackage

// File: rtl/wsr_free_list.sv
`timescale 1ns/1ps
module wsr_free_list #(
  parameter int DEPTH  = 32,
  parameter int PHYS_W = 6,
  parameter int GROUP  = 4,
  parameter int NLOG   = 16,
  parameter int NSUB   = 2,
  parameter int SUB_ID = 0,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int FCNT_W = $clog2(DEPTH + 1),
  localparam int CNT_W  = $clog2(GROUP + 1),
  localparam int SUB_W  = $clog2(NSUB),
  localparam int INIT   = DEPTH - NLOG / NSUB
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CNT_W-1:0]        pop_n,
  input  logic                    push_en,
  input  logic [PHYS_W-1:0]       push_preg,
  output logic [FCNT_W-1:0]       avail,
  output logic [GROUP*PHYS_W-1:0] heads
);
  logic [PHYS_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [FCNT_W-1:0] cnt_q;

  assign avail = cnt_q;

  genvar g;
  generate
    for (g = 0; g < GROUP; g++) begin : g_head
      assign heads[g*PHYS_W +: PHYS_W] = mem[head_q + PTR_W'(g)];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= PTR_W'(INIT);
      cnt_q  <= FCNT_W'(INIT);
      for (int k = 0; k < DEPTH; k++)
        mem[k] <= (k < INIT) ? PHYS_W'(NLOG + SUB_ID + k * NSUB) : '0;
    end else begin
      if (push_en) begin
        mem[tail_q] <= push_preg;
        tail_q      <= tail_q + 1'b1;
      end
      head_q <= head_q + PTR_W'(pop_n);
      cnt_q  <= cnt_q + FCNT_W'(push_en) - FCNT_W'(pop_n);
    end
  end

  // R8: the stall logic must never let a list go below empty
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    FCNT_W'(pop_n) <= cnt_q);
  // R9: a returned register always finds a free slot
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    push_en |-> (int'(cnt_q) < DEPTH));
  // R2: only registers of this subset ever leave this list
  p_head_subset_r2: assert property (@(posedge clk) disable iff (rst)
    (pop_n != '0) |-> (heads[SUB_W-1:0] == SUB_W'(SUB_ID)));
endmodule

// File: rtl/wsr_group_ctl.sv
`timescale 1ns/1ps
module wsr_group_ctl #(
  parameter int GROUP = 4,
  parameter int NSUB  = 2,
  localparam int SUB_W = $clog2(NSUB),
  localparam int CNT_W = $clog2(GROUP + 1),
  localparam int RK_W  = $clog2(GROUP)
) (
  input  logic [GROUP-1:0]       dst_vld,
  input  logic [GROUP*SUB_W-1:0] subset,
  output logic [NSUB*CNT_W-1:0]  need,
  output logic [GROUP*RK_W-1:0]  rank
);
  logic [CNT_W-1:0] tally [NSUB];
  logic [SUB_W-1:0] s;

  always_comb begin
    for (int t = 0; t < NSUB; t++) tally[t] = '0;
    rank = '0;
    s    = '0;
    for (int i = 0; i < GROUP; i++) begin
      s = subset[i*SUB_W +: SUB_W];
      rank[i*RK_W +: RK_W] = tally[s][RK_W-1:0];
      if (dst_vld[i]) tally[s] = tally[s] + 1'b1;
    end
    for (int t = 0; t < NSUB; t++) need[t*CNT_W +: CNT_W] = tally[t];
  end
endmodule

// File: rtl/wsr_renamer.sv
`timescale 1ns/1ps
module wsr_renamer #(
  parameter int GROUP = wsr_pkg::DEF_GROUP,
  parameter int NLOG  = wsr_pkg::DEF_NLOG,
  parameter int NPHYS = wsr_pkg::DEF_NPHYS,
  parameter int NSUB  = wsr_pkg::DEF_NSUB,
  localparam int LOG_W  = $clog2(NLOG),
  localparam int PHYS_W = $clog2(NPHYS),
  localparam int SUB_W  = $clog2(NSUB)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [GROUP-1:0]        in_dst_vld,
  input  logic [GROUP*LOG_W-1:0]  in_dst_log,
  input  logic [GROUP*LOG_W-1:0]  in_srca_log,
  input  logic [GROUP*LOG_W-1:0]  in_srcb_log,
  input  logic [GROUP*SUB_W-1:0]  in_subset,
  input  logic                    ret_valid,
  input  logic [PHYS_W-1:0]       ret_preg,
  output logic                    grp_stall,
  output logic                    out_valid,
  output logic [GROUP-1:0]        out_dst_vld,
  output logic [GROUP*PHYS_W-1:0] out_dst_preg,
  output logic [GROUP*PHYS_W-1:0] out_old_preg,
  output logic [GROUP*PHYS_W-1:0] out_srca_preg,
  output logic [GROUP*PHYS_W-1:0] out_srcb_preg
);
  localparam int DEPTH  = NPHYS / NSUB;
  localparam int CNT_W  = $clog2(GROUP + 1);
  localparam int RK_W   = $clog2(GROUP);
  localparam int FCNT_W = $clog2(DEPTH + 1);

  logic [LOG_W-1:0]        dlog [GROUP];
  logic [LOG_W-1:0]        alog [GROUP];
  logic [LOG_W-1:0]        blog [GROUP];
  logic [SUB_W-1:0]        sub  [GROUP];
  logic [RK_W-1:0]         rnk  [GROUP];
  logic [NSUB*CNT_W-1:0]   need_pk;
  logic [GROUP*RK_W-1:0]   rank_pk;
  logic [CNT_W-1:0]        need  [NSUB];
  logic [FCNT_W-1:0]       avail [NSUB];
  logic [GROUP*PHYS_W-1:0] heads [NSUB];
  logic [CNT_W-1:0]        pop_n [NSUB];
  logic [NSUB-1:0]         push_en;
  logic [PHYS_W-1:0]       new_preg [GROUP];
  logic [PHYS_W-1:0]       srca [GROUP];
  logic [PHYS_W-1:0]       srcb [GROUP];
  logic [PHYS_W-1:0]       oldp [GROUP];
  logic [PHYS_W-1:0]       map_q [NLOG];
  logic                    short, accept;

  genvar g;
  generate
    for (g = 0; g < GROUP; g++) begin : g_lane
      assign dlog[g] = in_dst_log[g*LOG_W +: LOG_W];
      assign alog[g] = in_srca_log[g*LOG_W +: LOG_W];
      assign blog[g] = in_srcb_log[g*LOG_W +: LOG_W];
      assign sub[g]  = in_subset[g*SUB_W +: SUB_W];
      assign rnk[g]  = rank_pk[g*RK_W +: RK_W];
      assign new_preg[g] = heads[sub[g]][rnk[g]*PHYS_W +: PHYS_W];
    end
  endgenerate

  wsr_group_ctl #(.GROUP(GROUP), .NSUB(NSUB)) u_ctl (
    .dst_vld(in_dst_vld), .subset(in_subset), .need(need_pk), .rank(rank_pk));

  generate
    for (g = 0; g < NSUB; g++) begin : g_list
      assign need[g]    = need_pk[g*CNT_W +: CNT_W];
      assign pop_n[g]   = accept ? need[g] : '0;
      assign push_en[g] = ret_valid && (ret_preg[SUB_W-1:0] == SUB_W'(g));
      wsr_free_list #(.DEPTH(DEPTH), .PHYS_W(PHYS_W), .GROUP(GROUP),
                      .NLOG(NLOG), .NSUB(NSUB), .SUB_ID(g)) u_fl (
        .clk(clk), .rst(rst), .pop_n(pop_n[g]), .push_en(push_en[g]),
        .push_preg(ret_preg), .avail(avail[g]), .heads(heads[g]));
    end
  endgenerate

  always_comb begin
    short = 1'b0;
    for (int s = 0; s < NSUB; s++)
      if (FCNT_W'(need[s]) > avail[s]) short = 1'b1;
  end
  assign grp_stall = in_valid && short;
  assign accept    = in_valid && !short;

  // Intra-group resolution: later j overrides earlier, so youngest producer wins
  always_comb begin
    for (int i = 0; i < GROUP; i++) begin
      srca[i] = map_q[alog[i]];
      srcb[i] = map_q[blog[i]];
      oldp[i] = map_q[dlog[i]];
      for (int j = 0; j < i; j++) begin
        if (in_dst_vld[j] && dlog[j] == alog[i]) srca[i] = new_preg[j];
        if (in_dst_vld[j] && dlog[j] == blog[i]) srcb[i] = new_preg[j];
        if (in_dst_vld[j] && dlog[j] == dlog[i]) oldp[i] = new_preg[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_dst_vld   <= '0;
      out_dst_preg  <= '0;
      out_old_preg  <= '0;
      out_srca_preg <= '0;
      out_srcb_preg <= '0;
      for (int l = 0; l < NLOG; l++) map_q[l] <= PHYS_W'(l);
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_dst_vld <= in_dst_vld;
        for (int i = 0; i < GROUP; i++) begin
          out_dst_preg[i*PHYS_W +: PHYS_W]  <= in_dst_vld[i] ? new_preg[i] : '0;
          out_old_preg[i*PHYS_W +: PHYS_W]  <= in_dst_vld[i] ? oldp[i] : '0;
          out_srca_preg[i*PHYS_W +: PHYS_W] <= srca[i];
          out_srcb_preg[i*PHYS_W +: PHYS_W] <= srcb[i];
        end
        for (int j = 0; j < GROUP; j++)
          if (in_dst_vld[j]) map_q[dlog[j]] <= new_preg[j];
      end
    end
  end

  // R8: a held-off group yields no result
  p_stall_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    grp_stall |=> !out_valid);
  // R10: an accepted group appears one clock later
  p_accept_emits_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !grp_stall) |=> out_valid);
  // R10: idle input produces idle output
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  generate
    for (g = 0; g < GROUP; g++) begin : g_chk
      // R2: destination subset follows the lane's subset field
      p_subset_match_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_dst_vld[g]) |->
          (out_dst_preg[g*PHYS_W +: SUB_W] == $past(sub[g])));
      for (genvar h = g + 1; h < GROUP; h++) begin : g_pair
        // R3: no register is handed to two lanes of one group
        p_distinct_r3: assert property (@(posedge clk) disable iff (rst)
          (out_valid && out_dst_vld[g] && out_dst_vld[h]) |->
            (out_dst_preg[g*PHYS_W +: PHYS_W] != out_dst_preg[h*PHYS_W +: PHYS_W]));
      end
    end
  endgenerate
endmodule

// File: tb/wsr_renamer_test.sv
`timescale 1ns/1ps
module wsr_renamer_test;
  localparam int G = 4;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, ret_valid;
  logic [3:0] in_dst_vld, in_subset;
  logic [15:0] in_dst_log, in_srca_log, in_srcb_log;
  logic [5:0] ret_preg;
  logic grp_stall, out_valid;
  logic [3:0] out_dst_vld;
  logic [23:0] out_dst_preg, out_old_preg, out_srca_preg, out_srcb_preg;

  always #2 clk = ~clk;

  wsr_renamer uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dst_vld(in_dst_vld),
    .in_dst_log(in_dst_log), .in_srca_log(in_srca_log), .in_srcb_log(in_srcb_log),
    .in_subset(in_subset), .ret_valid(ret_valid), .ret_preg(ret_preg),
    .grp_stall(grp_stall), .out_valid(out_valid), .out_dst_vld(out_dst_vld),
    .out_dst_preg(out_dst_preg), .out_old_preg(out_old_preg),
    .out_srca_preg(out_srca_preg), .out_srcb_preg(out_srcb_preg));

  int checks = 0, errors = 0;
  bit finished = 0;
  int mdl_map [16];
  int fl0 [$];
  int fl1 [$];
  int pool [$];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fsize(input int s);
    return (s == 0) ? fl0.size() : fl1.size();
  endfunction
  function automatic int fget(input int s, input int k);
    return (s == 0) ? fl0[k] : fl1[k];
  endfunction

  // Applies one cycle at a negedge; returns at the following negedge
  task automatic cycle(input bit v, input bit [3:0] dv, input int dl[4],
                       input int sa[4], input int sb[4], input bit [3:0] sv,
                       input bit rv, input int rp);
    int tally[2];
    int e_new[4], e_sa[4], e_sb[4], e_old[4];
    bit e_stall;
    in_valid = v; in_dst_vld = dv; in_subset = sv;
    ret_valid = rv; ret_preg = 6'(rp);
    for (int i = 0; i < G; i++) begin
      in_dst_log[i*4 +: 4]  = 4'(dl[i]);
      in_srca_log[i*4 +: 4] = 4'(sa[i]);
      in_srcb_log[i*4 +: 4] = 4'(sb[i]);
    end
    tally[0] = 0; tally[1] = 0;
    for (int i = 0; i < G; i++) if (dv[i]) tally[sv[i]]++;
    e_stall = v && (tally[0] > fsize(0) || tally[1] > fsize(1));
    #1;
    chk("R8 stall flag", int'(grp_stall), int'(e_stall));
    if (v && !e_stall) begin
      tally[0] = 0; tally[1] = 0;
      for (int i = 0; i < G; i++) begin
        e_new[i] = 0;
        if (dv[i]) begin
          e_new[i] = fget(sv[i], tally[sv[i]]);
          tally[sv[i]]++;
        end
      end
      for (int i = 0; i < G; i++) begin
        e_sa[i] = mdl_map[sa[i]]; e_sb[i] = mdl_map[sb[i]];
        e_old[i] = dv[i] ? mdl_map[dl[i]] : 0;
        for (int j = 0; j < i; j++) if (dv[j]) begin
          if (dl[j] == sa[i]) e_sa[i] = e_new[j];
          if (dl[j] == sb[i]) e_sb[i] = e_new[j];
          if (dv[i] && dl[j] == dl[i]) e_old[i] = e_new[j];
        end
      end
      for (int k = 0; k < tally[0]; k++) void'(fl0.pop_front());
      for (int k = 0; k < tally[1]; k++) void'(fl1.pop_front());
      for (int j = 0; j < G; j++) if (dv[j]) mdl_map[dl[j]] = e_new[j];
      for (int j = 0; j < G; j++) if (dv[j]) pool.push_back(e_old[j]);
    end
    if (rv) begin
      if ((rp & 1) == 0) fl0.push_back(rp); else fl1.push_back(rp);
    end
    @(posedge clk); #1;
    if (v && !e_stall) begin
      chk("R10 out_valid after accept", int'(out_valid), 1);
      for (int i = 0; i < G; i++) begin
        chk("R2/R3 new destination", int'(out_dst_preg[i*6 +: 6]), e_new[i]);
        chk("R7 old mapping", int'(out_old_preg[i*6 +: 6]), e_old[i]);
        chk("R4/R5 source a", int'(out_srca_preg[i*6 +: 6]), e_sa[i]);
        chk("R4/R5 source b", int'(out_srcb_preg[i*6 +: 6]), e_sb[i]);
      end
    end else if (e_stall) begin
      chk("R8 no result when held off", int'(out_valid), 0);
    end else begin
      chk("R10 no result when idle", int'(out_valid), 0);
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int dl[4], sa[4], sb[4];
    int r0, rp, idx;
    bit rv;
    void'($urandom(32'h5eed_2024));
    rst = 1'b1; in_valid = 0; in_dst_vld = 0; in_subset = 0;
    in_dst_log = 0; in_srca_log = 0; in_srcb_log = 0; ret_valid = 0; ret_preg = 0;
    for (int l = 0; l < 16; l++) mdl_map[l] = l;
    for (int k = 0; k < 24; k++) begin fl0.push_back(16 + 2*k); fl1.push_back(17 + 2*k); end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 out_valid low after reset", int'(out_valid), 0);
    chk("R1 no stall after reset", int'(grp_stall), 0);
    @(negedge clk);

    // R1/R4/R6/R7: directed group, logical 1 written twice, read later
    dl = '{1, 2, 1, 3}; sa = '{1, 1, 5, 1}; sb = '{4, 2, 2, 9};
    cycle(1, 4'b1111, dl, sa, sb, 4'b1010, 0, 0);
    chk("R1 first even register", int'(out_dst_preg[5:0]), 16);
    chk("R1 first odd register", int'(out_dst_preg[11:6]), 17);
    chk("R1 identity map for source", int'(out_srca_preg[5:0]), 1);

    // R6: youngest writer of logical 1 is visible in the next group
    dl = '{0, 0, 0, 0}; sa = '{1, 2, 3, 0}; sb = '{1, 1, 1, 1};
    cycle(1, 4'b0000, dl, sa, sb, 4'b0000, 0, 0);
    chk("R6 youngest writer in map", int'(out_srca_preg[5:0]), 18);

    // R8: drain even list with all-even groups until the stall appears
    dl = '{4, 5, 6, 7}; sa = '{4, 5, 6, 7}; sb = '{0, 1, 2, 3};
    while (fsize(0) >= 4) cycle(1, 4'b1111, dl, sa, sb, 4'b0000, 0, 0);
    chk("R8 even list short", int'(fsize(0) < 4), 1);
    cycle(1, 4'b1111, dl, sa, sb, 4'b0000, 0, 0);
    // odd-only group still proceeds while even is short
    cycle(1, 4'b0011, dl, sa, sb, 4'b0011, 0, 0);
    // R9: refill the even list through the retire port
    while (pool.size() > 0 && fsize(0) < 8) begin
      rp = pool.pop_front();
      cycle(0, 4'b0000, dl, sa, sb, 4'b0000, 1, rp);
    end
    cycle(1, 4'b1111, dl, sa, sb, 4'b0000, 0, 0);

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      r0 = int'($urandom);
      for (int i = 0; i < G; i++) begin
        dl[i] = int'($urandom % 16); sa[i] = int'($urandom % 16); sb[i] = int'($urandom % 16);
      end
      rv = 0; rp = 0;
      if (pool.size() > 0 && ($urandom % 4) != 0) begin
        idx = int'($urandom % pool.size());
        rp = pool[idx]; pool.delete(idx); rv = 1;
      end
      cycle((r0 % 3) != 0, 4'($urandom), dl, sa, sb, 4'($urandom), rv, rp);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule